// File: doc/BRIEF.md
# Double-Data-Rate to Half-Rate Word Gatherer

This block receives a data bus that presents a fresh word at every rising and every falling edge of a fast clock. It regroups that stream onto a second clock that runs at half the fast rate and comes from the same source. Each slow cycle, the block presents four consecutive words side by side, together with a valid flag. Between them, those four words cover two fast periods.

Inside the fast domain, a toggle register marks each fast period as even or odd. The first rising edge after reset is defined as even. Four capture registers each load on one combination of edge and parity:

- rising edge, even period
- falling edge, even period
- rising edge, odd period
- falling edge, odd period

Each capture register is therefore rewritten only once every two fast periods. The slow domain copies all four registers at its rising edge.

Reset is asynchronous and active low. The integrator must release it while the slow clock is low, so that the first fast rising edge afterwards coincides with a slow rising edge.

Top module: `ddr_halfrate_capture`

## Requirements
- R1: While rst_n is low, grp_valid is 0 and grp_dout is all zeros, whatever the clocks and din are doing.
- R2: grp_valid stays 0 across the first slow rising edge after reset release. It becomes 1 at the second slow rising edge and stays 1 until the next reset.
- R3: The slot layout is as follows:
  - bits [W-1:0]: the word sampled at the rising edge of the even period.
  - bits [2W-1:W]: the word sampled at the falling edge of the even period.
  - bits [3W-1:2W]: the word sampled at the rising edge of the following odd period.
  - bits [4W-1:3W]: the word sampled at the falling edge of that odd period.
- R4: No word is dropped or repeated. Valid group n holds stream words 4n to 4n+3, counting from word 0 at the first fast rising edge after reset release.
- R5: The first fast rising edge after reset release starts an even period, and parity alternates on every later fast rising edge. Given the release rule above, every slow rising edge therefore begins an even period.
- R6: Each capture register loads only at its own edge kind and parity. The two rising-edge registers never change at the same fast rising edge, and the two falling-edge registers never change at the same fast falling edge.
- R7: Every data bit passes through unchanged for any pattern: counting, alternating ones and zeros, walking one, scrambled.
- R8: Asserting rst_n in the middle of a stream restarts grouping. After the new release, grp_valid is again 0 for one slow edge, and the first group is aligned to the new word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock; din is sampled on both of its edges |
| clk_slow | input | 1 | Half-rate clock from the same source, rising with an even fast period |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| din | input | DATA_W | Double-data-rate input word |
| grp_dout | output | 4*DATA_W | Four gathered words, earliest in the lowest slot |
| grp_valid | output | 1 | High when grp_dout holds a full group |

## Verification
The bench targets the following corner cases:

- **Slot order.** A swap of the rising and falling slots, or of the even and odd pairs, shows up as permuted words under a counting pattern.
- **Period parity.** A wrong reset value of the parity register shifts every group by one fast period, so each slot holds a word from the neighbouring period.
- **Fill latency.** A flag raised one slow edge early presents the reset-value registers as data. One raised late hides the first real group.
- **Mid-stream reset.** A reset in the middle of a stream must restart the grouping. A design that kept stale fill state or stale parity would misalign the first group after the new release.

// File: rtl/ddr_hr_pkg.sv
package ddr_hr_pkg;

   // Words gathered per slow cycle: two fast periods, two edges each.
   localparam int unsigned HR_SLOTS = 4;

   // Slow edges before the capture registers all hold post-reset data.
   localparam int unsigned HR_FILL  = 2;

   // Slot s is captured on the falling edge when bit 0 of s is set.
   function automatic bit slot_on_fall(input int unsigned s);
      return (s % 2) == 1;
   endfunction

   // Slot s belongs to the odd fast period when bit 1 of s is set.
   function automatic bit slot_odd(input int unsigned s);
      return ((s / 2) % 2) == 1;
   endfunction

endpackage

// File: rtl/ddr_hr_phase.sv
module ddr_hr_phase (
   input  logic clk_fast,
   input  logic rst_n,
   output logic rise_odd,   // parity of the period a rising edge begins
   output logic fall_odd    // parity of the period a falling edge sits in
);

   // Holds the parity of the current period; the reset value 1 makes the
   // first rising edge after release open an even period.
   logic par_q;

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) par_q <= 1'b1;
      else        par_q <= ~par_q;
   end

   assign rise_odd = ~par_q;
   assign fall_odd = par_q;

endmodule

// File: rtl/ddr_hr_edge_reg.sv
module ddr_hr_edge_reg #(
   parameter int unsigned W       = 16,
   parameter bit          ON_FALL = 1'b0,
   parameter bit          ODD     = 1'b0
) (
   input  logic         clk_fast,
   input  logic         rst_n,
   input  logic         period_odd,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic hit;
   assign hit = (period_odd == ODD);

   generate
      if (ON_FALL) begin : g_fall
         always_ff @(negedge clk_fast or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= d;
         end
         // R6: outside its own parity the register keeps its word.
         assert_hold_off_parity_R6: assert property (
            @(negedge clk_fast) disable iff (!rst_n)
            !hit |=> $stable(q));
      end else begin : g_rise
         always_ff @(posedge clk_fast or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= d;
         end
         // R6: outside its own parity the register keeps its word.
         assert_hold_off_parity_R6: assert property (
            @(posedge clk_fast) disable iff (!rst_n)
            !hit |=> $stable(q));
      end
   endgenerate

endmodule

// File: rtl/ddr_hr_gather.sv
module ddr_hr_gather
   import ddr_hr_pkg::*;
#(
   parameter int unsigned W     = 16,
   parameter int unsigned SLOTS = HR_SLOTS
) (
   input  logic                      clk_slow,
   input  logic                      rst_n,
   input  logic [SLOTS-1:0][W-1:0]   words,
   output logic [SLOTS*W-1:0]        grp,
   output logic                      grp_valid
);

   localparam int unsigned FILL = HR_FILL;

   logic [SLOTS-1:0][W-1:0] grp_q;
   logic [FILL-1:0]         fill_q;

   always_ff @(posedge clk_slow or negedge rst_n) begin
      if (!rst_n) begin
         grp_q  <= '0;
         fill_q <= '0;
      end else begin
         grp_q  <= words;
         fill_q <= {fill_q[FILL-2:0], 1'b1};
      end
   end

   assign grp       = grp_q;
   assign grp_valid = fill_q[FILL-1];

   // R2: once raised, the valid flag only falls through reset.
   assert_valid_sticks_R2: assert property (
      @(posedge clk_slow) disable iff (!rst_n)
      grp_valid |=> grp_valid);

endmodule

// File: rtl/ddr_halfrate_capture.sv
module ddr_halfrate_capture
   import ddr_hr_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic                         clk_fast,
   input  logic                         clk_slow,
   input  logic                         rst_n,
   input  logic [DATA_W-1:0]            din,
   output logic [HR_SLOTS*DATA_W-1:0]   grp_dout,
   output logic                         grp_valid
);

   localparam int unsigned SLOTS = HR_SLOTS;

   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (HR_FILL < 2) begin : g_bad_fill
      $error("fill depth must be at least 2");
   end

   logic                        rise_odd;
   logic                        fall_odd;
   logic [SLOTS-1:0][DATA_W-1:0] cap;

   ddr_hr_phase u_phase (
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .rise_odd (rise_odd),
      .fall_odd (fall_odd)
   );

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam bit FALL = slot_on_fall(s);
      localparam bit ODDP = slot_odd(s);
      logic par;
      assign par = FALL ? fall_odd : rise_odd;
      ddr_hr_edge_reg #(
         .W       (DATA_W),
         .ON_FALL (FALL),
         .ODD     (ODDP)
      ) u_cap (
         .clk_fast   (clk_fast),
         .rst_n      (rst_n),
         .period_odd (par),
         .d          (din),
         .q          (cap[s])
      );
   end

   ddr_hr_gather #(
      .W     (DATA_W),
      .SLOTS (SLOTS)
   ) u_gather (
      .clk_slow  (clk_slow),
      .rst_n     (rst_n),
      .words     (cap),
      .grp       (grp_dout),
      .grp_valid (grp_valid)
   );

   // R5: each slow rising edge must meet the close of an odd period.
   assert_slow_edge_even_R5: assert property (
      @(posedge clk_slow) disable iff (!rst_n)
      fall_odd);

   // R6: the two rising-edge registers never load at the same edge.
   assert_rise_pair_exclusive_R6: assert property (
      @(posedge clk_fast) disable iff (!rst_n)
      1'b1 |=> ($stable(cap[0]) || $stable(cap[2])));

   // R6: the two falling-edge registers never load at the same edge.
   assert_fall_pair_exclusive_R6: assert property (
      @(negedge clk_fast) disable iff (!rst_n)
      1'b1 |=> ($stable(cap[1]) || $stable(cap[3])));

endmodule

// File: tb/ddr_halfrate_capture_test.sv
module ddr_halfrate_capture_test;

   localparam int W    = 16;
   localparam int P    = 8;      // fast clock period
   localparam int LOGN = 4096;

   logic           clk_fast = 1'b0;
   logic           clk_slow = 1'b0;
   logic           rst_n    = 1'b0;
   logic [W-1:0]   din      = '0;
   logic [4*W-1:0] grp_dout;
   logic           grp_valid;

   int n_chk = 0;
   int n_bad = 0;
   int mode  = 0;
   int drv_j = 0;
   int lg_n  = 0;
   bit done  = 1'b0;
   logic [W-1:0] lg [LOGN];

   ddr_halfrate_capture #(.DATA_W(W)) uut (
      .clk_fast  (clk_fast),
      .clk_slow  (clk_slow),
      .rst_n     (rst_n),
      .din       (din),
      .grp_dout  (grp_dout),
      .grp_valid (grp_valid)
   );

   // Both clocks from one process: the slow clock flips on each fast rise.
   initial begin
      forever begin
         #(P/2);
         clk_fast = 1'b1;
         clk_slow = ~clk_slow;
         #(P/2);
         clk_fast = 1'b0;
      end
   end

   function automatic logic [W-1:0] pat(input int m, input int j);
      logic [31:0] t;
      case (m)
         0: t = j;
         1: t = (j % 2 == 1) ? 32'h0000_AAAA : 32'h0000_5555;
         2: t = 32'h1 << (j % W);
         default: t = (j * 40503) ^ (j >> 3) ^ 32'h0000_3C5A;
      endcase
      return t[W-1:0];
   endfunction

   // Centre-aligned source: each word settles a quarter period after an edge.
   always @(clk_fast) begin
      #(P/4);
      din = pat(mode, drv_j);
      drv_j++;
   end

   // Record the stream as seen at each fast edge since reset release.
   always @(clk_fast) begin
      if (!rst_n) lg_n = 0;
      else begin
         if (lg_n < LOGN) lg[lg_n] = din;
         lg_n++;
      end
   end

   task automatic chk(input bit ok, input string req,
                      input logic [4*W-1:0] act, input logic [4*W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk_slow);
      @(negedge clk_slow);
      @(negedge clk_fast);
      #1 rst_n = 1'b1;
   endtask

   // Runs n slow edges after a fresh release and checks every group.
   task automatic run_stream(input int m, input int n, input string req);
      logic [4*W-1:0] exp;
      mode = m;
      apply_reset();
      for (int s = 0; s < n; s++) begin
         @(posedge clk_slow);
         #(P/4);
         if (s == 0) begin
            chk(grp_valid == 1'b0, "R2 valid low at first slow edge",
                {63'd0, grp_valid}, '0);
         end else begin
            chk(grp_valid == 1'b1, "R2 valid high from second slow edge",
                {63'd0, grp_valid}, 64'd1);
            for (int k = 0; k < 4; k++)
               exp[k*W +: W] = lg[4*(s-1) + k];
            chk(grp_dout == exp, req, grp_dout, exp);
         end
      end
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      #(3*P);
      chk(grp_valid == 1'b0 && grp_dout == '0, "R1 outputs during reset",
          grp_dout, '0);
   endtask

   task automatic t_fill_and_order();
      // R2 R3 R4 R5: a counting stream exposes any slot swap or shift.
      run_stream(0, 24, "R3 R4 R5 counting group");
   endtask

   task automatic t_patterns();
      // R6 R7: each capture register keeps its word for two fast periods.
      run_stream(1, 12, "R7 R6 alternating group");
      run_stream(2, 20, "R7 walking-one group");
      run_stream(3, 30, "R7 R4 scrambled group");
   endtask

   task automatic t_mid_reset();
      run_stream(0, 9, "R8 stream before reset");
      #3 rst_n = 1'b0;
      #1;
      chk(grp_valid == 1'b0 && grp_dout == '0, "R1 R8 async reset clears",
          grp_dout, '0);
      run_stream(3, 10, "R8 regroup after reset");
   endtask

   initial begin
      #(P*150000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_fill_and_order();
      t_patterns();
      t_mid_reset();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule